// File: doc/BRIEF.md
# Single-Wire Slave Bit Interface

This block is the bottom layer of a slave on a single-wire, open-drain bus where every transfer is a time slot. The host starts each slot with a falling edge. The block watches the line through a synchronizer and a glitch filter. It turns the host's write slots into received bits. It answers read slots by pulling the line low for a 0 or leaving it released for a 1. A low period far longer than any slot is taken as a bus reset. The block reports the reset to the layer above and replies with its own presence pulse. All timing is counted in clock cycles and derived from the `CLK_HZ` parameter, which must be a whole number of MHz.

The command layer above tells the block, through `rd_slot`, whether the next slot is a read. It holds the bit to send on `rd_bit` ahead of the slot. In return it receives `bit_valid`/`bit_val` for a decoded write bit, `rd_req` when a read bit has been consumed, and `rst_seen` when a reset is detected. The line may stay idle (high) for any length of time between slots without any loss of state.

The controller is a Moore state machine with eight states:
- IDLE: the line is high.
- SLOT: a write slot is in progress.
- RD_DRIVE: the block is sending a read 0.
- WAIT_HIGH: the slot has been handled and the block waits for the line to return high.
- RST_LOW: a reset has been seen and the line is still low.
- PPD: the delay before the presence pulse.
- PRESENCE: the presence pulse is being driven.
- PP_REL: the block waits for the line to return high after the presence pulse.

The transitions are:
- IDLE→SLOT on a falling edge when `rd_slot`=0.
- IDLE→RD_DRIVE on a falling edge when `rd_slot`=1 and `rd_bit`=0.
- IDLE→WAIT_HIGH on a falling edge when `rd_slot`=1 and `rd_bit`=1.
- SLOT→WAIT_HIGH at the sample point.
- RD_DRIVE→WAIT_HIGH when the hold time ends.
- WAIT_HIGH→IDLE once the line is high.
- Any state → RST_LOW when the low-time limit is hit.
- RST_LOW→PPD on release.
- PPD→PRESENCE after the delay.
- PRESENCE→PP_REL after the pulse length.
- PP_REL→IDLE once the line is high.

Top module: `sw_slave_phy`

## Requirements
- R1: After `rst_n` is released, `bus_pull`, `bit_valid`, `rd_req` and `rst_seen` are all 0.
- R2: A continuous filtered low of at least `RST_US` (240 us) gives exactly one `rst_seen` pulse. A low of 235 us gives none.
- R3: After a reset, once the line is released, `bus_pull` rises 30 to 34 us later and stays high for exactly `PP_US` (120 us). The output only ever pulls low, through `bus_pull`=1, or releases the line.
- R4: In a write slot (`rd_slot`=0), the line is sampled 30 us after the filtered falling edge. Exactly one `bit_valid` pulse follows, with `bit_val` equal to the sampled level. A 60 us low gives 0, and a 5 us low gives 1.
- R5: In a read slot (`rd_slot`=1), `rd_req` pulses once per slot. If `rd_bit`=0, the block pulls the line for exactly `RDH_US` (30 us) starting at the detected fall, so the line reads low 15 us after the fall. If `rd_bit`=1, it does not pull at all. No `bit_valid` is produced in a read slot.
- R6: A low pulse shorter than 1 us on the line is ignored: no `bit_valid`, no `rd_req` and no pull.
- R7: An idle (high) line of any length between slots does not disturb the decoding of the next slot.
- R8: A reset that arrives during a read-0 slot ends that slot. It gives one `rst_seen` pulse, followed by a full presence pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 1 | Raw level of the bus line (1 = high) |
| bus_pull | output | 1 | Pull-down enable, 1 = drive line low, 0 = release |
| rd_slot | input | 1 | Next slot is a read slot |
| rd_bit | input | 1 | Bit to send in the next read slot |
| bit_valid | output | 1 | One-cycle strobe: a write bit was decoded |
| bit_val | output | 1 | Value of the decoded write bit |
| rd_req | output | 1 | One-cycle strobe: a read slot began and `rd_bit` was taken |
| rst_seen | output | 1 | One-cycle strobe: a bus reset was detected |

## Verification
The case where two functions meet is a reset arriving while a slot is being served. In a read-0 slot, the block's own pull and the host's long low overlap on the line, and the low-time meter must still fire from inside WAIT_HIGH. The bench provokes this by holding the line low for 300 us after a read-0 slot has started. It then expects one `rst_seen` pulse, the single `rd_req` of that slot, and a full presence pulse of the correct length. The low times of 235 us and 245 us are a related case: the longest low that is still a slot and the shortest low that is a reset.

// File: rtl/sw_phy_pkg.sv
package sw_phy_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLOT,
        ST_RD_DRIVE,
        ST_WAIT_HIGH,
        ST_RST_LOW,
        ST_PPD,
        ST_PRESENCE,
        ST_PP_REL
    } phy_state_t;

    function automatic int us_to_cyc(input int clk_hz, input int us);
        return (clk_hz / 1000000) * us;
    endfunction

endpackage

// File: rtl/sw_bus_filter.sv
module sw_bus_filter #(
    parameter int GL_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic clean
);
    localparam int CW = $clog2(GL_CYC + 1) + 1;

    logic       meta, sync;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= 1'b1;
            sync <= 1'b1;
        end else begin
            meta <= raw_in;
            sync <= meta;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clean <= 1'b1;
            cnt   <= '0;
        end else if (sync == clean) begin
            cnt <= '0;
        end else if (cnt == CW'(GL_CYC - 1)) begin
            clean <= sync;
            cnt   <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sw_low_meter.sv
module sw_low_meter #(
    parameter int LIMIT_CYC = 960
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    output logic limit_hit
);
    localparam int LW = $clog2(LIMIT_CYC + 1) + 1;

    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (line)
            low_cnt <= '0;
        else if (low_cnt != LW'(LIMIT_CYC))
            low_cnt <= low_cnt + 1'b1;
    end

    assign limit_hit = !line && (low_cnt == LW'(LIMIT_CYC - 1));
endmodule

// File: rtl/sw_slave_phy.sv
module sw_slave_phy
    import sw_phy_pkg::*;
#(
    parameter int CLK_HZ  = 4000000,
    parameter int RST_US  = 240,
    parameter int PPD_US  = 30,
    parameter int PP_US   = 120,
    parameter int SAMP_US = 30,
    parameter int RDH_US  = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_in,
    output logic bus_pull,
    input  logic rd_slot,
    input  logic rd_bit,
    output logic bit_valid,
    output logic bit_val,
    output logic rd_req,
    output logic rst_seen
);
    localparam int GL_CYC   = us_to_cyc(CLK_HZ, 1);
    localparam int RST_CYC  = us_to_cyc(CLK_HZ, RST_US);
    localparam int PPD_CYC  = us_to_cyc(CLK_HZ, PPD_US);
    localparam int PP_CYC   = us_to_cyc(CLK_HZ, PP_US);
    localparam int SAMP_CYC = us_to_cyc(CLK_HZ, SAMP_US);
    localparam int RDH_CYC  = us_to_cyc(CLK_HZ, RDH_US);
    localparam int MAX1     = (PP_CYC > PPD_CYC) ? PP_CYC : PPD_CYC;
    localparam int MAX2     = (SAMP_CYC > RDH_CYC) ? SAMP_CYC : RDH_CYC;
    localparam int TMAX     = (MAX1 > MAX2) ? MAX1 : MAX2;
    localparam int TW       = $clog2(TMAX + 1) + 1;

    logic          line;
    logic          rst_hit;
    phy_state_t    state, state_n;
    logic [TW-1:0] tcnt;

    sw_bus_filter #(.GL_CYC(GL_CYC)) u_filter (
        .clk(clk), .rst_n(rst_n), .raw_in(bus_in), .clean(line)
    );

    sw_low_meter #(.LIMIT_CYC(RST_CYC)) u_meter (
        .clk(clk), .rst_n(rst_n), .line(line), .limit_hit(rst_hit)
    );

    // state register and state timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            tcnt  <= '0;
        end else begin
            state <= state_n;
            if (state_n != state)
                tcnt <= '0;
            else if (tcnt != '1)
                tcnt <= tcnt + 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:
                if (!line)
                    state_n = !rd_slot ? ST_SLOT :
                              (rd_bit ? ST_WAIT_HIGH : ST_RD_DRIVE);
            ST_SLOT:
                if (tcnt == TW'(SAMP_CYC - 1)) state_n = ST_WAIT_HIGH;
            ST_RD_DRIVE:
                if (tcnt == TW'(RDH_CYC - 1)) state_n = ST_WAIT_HIGH;
            ST_WAIT_HIGH:
                if (line) state_n = ST_IDLE;
            ST_RST_LOW:
                if (line) state_n = ST_PPD;
            ST_PPD:
                if (tcnt == TW'(PPD_CYC - 1)) state_n = ST_PRESENCE;
            ST_PRESENCE:
                if (tcnt == TW'(PP_CYC - 1)) state_n = ST_PP_REL;
            ST_PP_REL:
                if (line) state_n = ST_IDLE;
            default:
                state_n = ST_IDLE;
        endcase
        if (rst_hit)
            state_n = ST_RST_LOW;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_valid <= 1'b0;
            bit_val   <= 1'b1;
            rd_req    <= 1'b0;
            rst_seen  <= 1'b0;
        end else begin
            bit_valid <= (state == ST_SLOT) && !rst_hit &&
                         (tcnt == TW'(SAMP_CYC - 1));
            if ((state == ST_SLOT) && (tcnt == TW'(SAMP_CYC - 1)))
                bit_val <= line;
            rd_req    <= (state == ST_IDLE) && !line && rd_slot && !rst_hit;
            rst_seen  <= rst_hit;
        end
    end

    assign bus_pull = (state == ST_PRESENCE) || (state == ST_RD_DRIVE);
endmodule

// File: rtl/sw_slave_phy_chk.sv
module sw_slave_phy_chk #(
    parameter int PP_CYC = 480
) (
    input logic clk,
    input logic rst_n,
    input logic bus_pull,
    input logic rd_bit,
    input logic bit_valid,
    input logic rd_req,
    input logic rst_seen
);
    logic [15:0] pull_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pull_run <= '0;
        else if (!bus_pull)
            pull_run <= '0;
        else if (pull_run != '1)
            pull_run <= pull_run + 1'b1;
    end

    // R2
    rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_seen |=> !rst_seen);

    // R3
    pull_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_pull |-> (pull_run < 16'(PP_CYC)));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bit_valid, rd_req, rst_seen}));

    // R4
    wr_no_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> !bus_pull);

    // R5
    rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (bus_pull == !$past(rd_bit)));

    // R8
    rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_seen |-> !bus_pull);
endmodule

bind sw_slave_phy sw_slave_phy_chk #(.PP_CYC(PP_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_pull(bus_pull), .rd_bit(rd_bit),
    .bit_valid(bit_valid), .rd_req(rd_req), .rst_seen(rst_seen)
);

// File: tb/tb_sw_slave_phy.sv
`timescale 1ns/1ps
module tb_sw_slave_phy;
    localparam int CPU     = 4;            // cycles per microsecond
    localparam int PP_EXP  = 120 * CPU;
    localparam int RDH_EXP = 30 * CPU;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_low = 1'b0;
    logic rd_slot = 1'b0;
    logic rd_bit = 1'b1;
    logic bus_in, bus_pull, bit_valid, bit_val, rd_req, rst_seen;

    always #2.5 clk = ~clk;

    assign bus_in = !(host_low || bus_pull);

    sw_slave_phy #(.CLK_HZ(CPU * 1000000)) dut (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_pull(bus_pull),
        .rd_slot(rd_slot), .rd_bit(rd_bit), .bit_valid(bit_valid),
        .bit_val(bit_val), .rd_req(rd_req), .rst_seen(rst_seen)
    );

    int checks = 0, errors = 0;
    int cyc = 0, nbits = 0, nreq = 0, nrst = 0, npulls = 0;
    int run = 0, last_run = 0, rise_cyc = 0;
    logic last_bit = 1'b1, prev_pull = 1'b0, done = 1'b0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (bit_valid) begin nbits <= nbits + 1; last_bit <= bit_val; end
        if (rd_req) nreq <= nreq + 1;
        if (rst_seen) nrst <= nrst + 1;
        if (bus_pull) begin
            run <= run + 1;
            if (!prev_pull) begin rise_cyc <= cyc; npulls <= npulls + 1; end
        end else if (prev_pull) begin
            last_run <= run;
            run <= 0;
        end
        prev_pull <= bus_pull;
    end

    int wd = 0;
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd == 190000 && !done) begin
            checks = checks + 1; errors = errors + 1;
            $display("FAIL watchdog: act %0d cycles exp < 190000", wd);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: act %0d exp %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic hold_low(input int us);
        host_low = 1'b1;
        cycles(us * CPU);
        host_low = 1'b0;
    endtask

    task automatic write_slot(input logic b, input string req);
        int nb, nr;
        nb = nbits; nr = nreq;
        rd_slot = 1'b0;
        hold_low(b ? 5 : 60);
        cycles((b ? 75 : 20) * CPU);
        chk(nbits == nb + 1, req, nbits - nb, 1);
        chk(last_bit == b, req, int'(last_bit), int'(b));
        chk(nreq == nr, req, nreq - nr, 0);
    endtask

    task automatic read_slot(input logic b, input string req);
        int nb, nr, np;
        logic seen;
        nb = nbits; nr = nreq; np = npulls;
        rd_slot = 1'b1; rd_bit = b;
        cycles(4);
        hold_low(2);
        cycles(13 * CPU);
        seen = bus_in;
        cycles(65 * CPU);
        rd_slot = 1'b0; rd_bit = 1'b1;
        chk(seen == b, req, int'(seen), int'(b));
        chk(nreq == nr + 1, req, nreq - nr, 1);
        chk(nbits == nb, req, nbits - nb, 0);
        if (b == 1'b0)
            chk(last_run == RDH_EXP, req, last_run, RDH_EXP);
        else
            chk(npulls == np, req, npulls - np, 0);
    endtask

    function automatic bit in_window(input int d);
        return (d >= 30 * CPU) && (d <= 34 * CPU);
    endfunction

    task automatic reset_pulse(input int us, input bit expect_rst, input string req);
        int nr, rel;
        nr = nrst;
        hold_low(us);
        rel = cyc;
        cycles(300 * CPU);
        chk(nrst == nr + (expect_rst ? 1 : 0), req, nrst - nr, expect_rst ? 1 : 0);
        if (expect_rst) begin
            chk(in_window(rise_cyc - rel), "R3 delay", rise_cyc - rel, 32 * CPU);
            chk(last_run == PP_EXP, "R3 length", last_run, PP_EXP);
        end
    endtask

    initial begin
        process::self().srandom(32'd1234);
        cycles(10);
        // R1
        chk(bus_pull == 1'b0 && bit_valid == 1'b0 && rd_req == 1'b0 && rst_seen == 1'b0,
            "R1 reset state", int'({bus_pull, bit_valid, rd_req, rst_seen}), 0);
        rst_n = 1'b1;
        cycles(10);
        chk(bus_pull == 1'b0, "R1 after release", int'(bus_pull), 0);

        reset_pulse(480, 1'b1, "R2 480us");
        begin
            int np;
            np = npulls;
            reset_pulse(235, 1'b0, "R2 235us");
            chk(npulls == np, "R2 no presence", npulls - np, 0);
        end
        reset_pulse(245, 1'b1, "R2 245us");

        write_slot(1'b0, "R4 write0");
        write_slot(1'b1, "R4 write1");
        read_slot(1'b0, "R5 read0");
        read_slot(1'b1, "R5 read1");

        // R6 glitch while a read-0 slot is armed
        begin
            int nb, nr, np;
            nb = nbits; nr = nreq; np = npulls;
            rd_slot = 1'b1; rd_bit = 1'b0;
            cycles(2);
            host_low = 1'b1; cycles(2); host_low = 1'b0;
            cycles(100 * CPU);
            chk(nbits == nb, "R6 no bit", nbits - nb, 0);
            chk(nreq == nr, "R6 no rd_req", nreq - nr, 0);
            chk(npulls == np, "R6 no pull", npulls - np, 0);
            rd_slot = 1'b0; rd_bit = 1'b1;
        end

        // R7 long idle then slots
        cycles(5000);
        write_slot(1'b0, "R7 after idle");
        cycles(3000);
        read_slot(1'b0, "R7 read after idle");

        for (int i = 0; i < 40; i++) begin
            logic is_rd, b;
            is_rd = logic'($urandom_range(0, 1));
            b = logic'($urandom_range(0, 1));
            cycles($urandom_range(4, 200));
            if (is_rd) read_slot(b, "R5 random");
            else       write_slot(b, "R4 random");
        end

        // R8 reset during a read-0 slot
        begin
            int nr, nq;
            nr = nrst; nq = nreq;
            rd_slot = 1'b1; rd_bit = 1'b0;
            cycles(4);
            reset_pulse(300, 1'b1, "R8 reset in slot");
            rd_slot = 1'b0; rd_bit = 1'b1;
            chk(nreq == nq + 1, "R8 one rd_req", nreq - nq, 1);
            chk(nrst == nr + 1, "R8 one rst_seen", nrst - nr, 1);
        end
        write_slot(1'b1, "R8 slot after reset");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule